// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the target (slave) side of a two-wire serial bus with a small internal register file behind it. It watches the bus clock and data lines, which it receives as plain inputs sampled by the system clock. It answers only when addressed: it pulls the data line low through a single open-drain enable output and otherwise leaves it released. A controller first writes a one-byte register pointer and then either writes a run of data bytes or issues a repeated START and reads a run of bytes back from the same pointer.

The pointer advances by one after every data byte that is written or read, and wraps at the end of the register file. Because the pointer is held across STOP and repeated START, a read can begin right where the last write or read left off. The block has no data stream at its edge: all payload lives in the internal register file. Its ports are the clock, the reset, the two sampled bus lines and the data-line pull-down enable, and none of them uses a handshake.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0, every register holds 0 and the pointer is 0.
- R2: The first byte after a START is shifted in MSB first as a 7-bit address followed by a direction bit (0 = write, 1 = read). When the address equals `TARGET_ADDR`, the target holds `sda_oe` at 1 during the ninth clock, which acknowledges the byte.
- R3: When the address does not match, the target keeps `sda_oe` at 0 and acknowledges nothing more until the next START or STOP.
- R4: In a write, the byte after the address is the register pointer. A value below `REG_COUNT` is acknowledged and loaded. A value of `REG_COUNT` or more is not acknowledged, the pointer keeps its value, and later bytes are not acknowledged.
- R5: Each data byte written after the pointer is acknowledged, stored at the pointer, and advances the pointer by one modulo `REG_COUNT`.
- R6: After a START with the read direction, the target drives the register at the pointer MSB first, eight bits per byte, releases the line in the ninth clock, and advances the pointer by one modulo `REG_COUNT` per byte.
- R7: When the controller leaves the line high in the ninth clock of a read byte (a NACK), the target stops driving and keeps `sda_oe` at 0 until the next START or STOP. When the controller pulls the line low instead (an ACK), the target sends the next byte.
- R8: A START in the middle of a byte returns the target to address reception, and a STOP returns it to idle. In both cases the partial byte is dropped, nothing is written, and `sda_oe` is 0.
- R9: `sda_oe` changes only in the system clock after a detected falling edge of the bus clock, or on a START or STOP. It never changes while the bus clock is high.
- R10: The pointer survives STOP and repeated START. A read with no pointer write starts where the last transfer left the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume a well-behaved bus. Bus-clock edges must be at least a few system clocks apart. The controller must change the data line only while the bus clock is low, except when it makes a START or STOP, and it must not make a START or STOP while the target is pulling the line low. Under those conditions the line enable can move only after a clock fall. The bench drives the bus with quarter periods of eight system clocks and keeps the data line steady while the clock is high. It places every START and STOP where the target has already released the line, including the aborts in the middle of a byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } tgt_state_e;

  typedef enum logic [1:0] {
    AK_ADDR_W,
    AK_ADDR_R,
    AK_PTR,
    AK_DATA
  } ack_kind_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lv,
  output logic sda_lv,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end

  assign scl_lv    = lvl[0];
  assign sda_lv    = lvl[1];
  assign scl_rise  = lvl[0] & ~prev[0];
  assign scl_fall  = ~lvl[0] & prev[0];
  assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];

endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (we && (int'(waddr) == i)) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lv,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rdata,
  output logic [PW-1:0] ptr,
  output logic          we,
  output logic [PW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          oe
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  tgt_state_e st;
  ack_kind_e  kind;
  logic [3:0] cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       mack;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      kind  <= AK_DATA;
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      mack  <= 1'b0;
      ptr   <= '0;
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
      oe    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st  <= ST_ADDR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_det) begin
        st  <= ST_IDLE;
        cnt <= '0;
        oe  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_sh <= {rx_sh[6:0], sda_lv};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (rx_sh[7:1] == TARGET_ADDR) begin
                  st   <= ST_ACK;
                  kind <= rx_sh[0] ? AK_ADDR_R : AK_ADDR_W;
                  oe   <= 1'b1;
                end else begin
                  st <= ST_HOLD;
                end
              end else if (st == ST_PTR) begin
                if (int'(rx_sh) < DEPTH) begin
                  ptr  <= rx_sh[PW-1:0];
                  st   <= ST_ACK;
                  kind <= AK_PTR;
                  oe   <= 1'b1;
                end else begin
                  st <= ST_HOLD;
                end
              end else begin
                we    <= 1'b1;
                waddr <= ptr;
                wdata <= rx_sh;
                ptr   <= bump(ptr);
                st    <= ST_ACK;
                kind  <= AK_DATA;
                oe    <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              unique case (kind)
                AK_ADDR_W: begin
                  st <= ST_PTR;
                  oe <= 1'b0;
                end
                AK_ADDR_R: begin
                  st    <= ST_RDAT;
                  tx_sh <= rdata;
                  oe    <= ~rdata[7];
                end
                default: begin
                  st <= ST_WDAT;
                  oe <= 1'b0;
                end
              endcase
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                cnt <= '0;
                oe  <= 1'b0;
                st  <= ST_RACK;
                ptr <= bump(ptr);
              end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
                oe    <= ~tx_sh[6];
                cnt   <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lv;
            end else if (scl_fall) begin
              if (mack) begin
                st    <= ST_RDAT;
                tx_sh <= rdata;
                oe    <= ~rdata[7];
                cnt   <= '0;
              end else begin
                st <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);

  p_hold_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> !oe);

  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe) && st == ST_ACK) |-> ($past(cnt) == 4'd8));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int REG_COUNT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PW = $clog2(REG_COUNT);

  logic          scl_lv, sda_lv, scl_rise, scl_fall, start_det, stop_det;
  logic [PW-1:0] ptr, waddr;
  logic          we;
  logic [7:0]    wdata, rdata;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lv(scl_lv), .sda_lv(sda_lv), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_regfile #(.DEPTH(REG_COUNT), .WIDTH(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata)
  );

  i2ct_engine #(.TARGET_ADDR(TARGET_ADDR), .DEPTH(REG_COUNT)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lv(sda_lv), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata(rdata), .ptr(ptr), .we(we), .waddr(waddr), .wdata(wdata), .oe(sda_oe)
  );

  p_quiet_on_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lv && $past(scl_lv) && !start_det && !stop_det) |=> $stable(sda_oe));

endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_scl = 1'b1;
  logic tb_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  logic [7:0] model [DEPTH];
  int mptr = 0;

  assign sda_line = ~(tb_low | sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target #(.TARGET_ADDR(ADDR), .REG_COUNT(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && tb_scl) viol++;
      oe_prev <= sda_oe;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_low = 1'b0; hold();
    tb_scl = 1'b1; hold();
    tb_low = 1'b1; hold();
    tb_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    tb_low = 1'b1; hold();
    tb_scl = 1'b1; hold();
    tb_low = 1'b0; hold();
    hold();
  endtask

  task automatic send_bit(input logic b);
    tb_low = ~b; hold();
    tb_scl = 1'b1; hold(); hold();
    tb_scl = 1'b0; hold();
  endtask

  task automatic recv_bit(output logic b);
    tb_low = 1'b0; hold();
    tb_scl = 1'b1; hold();
    b = sda_line; hold();
    tb_scl = 1'b0; hold();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ackd);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ackd = ~a;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(last);
  endtask

  task automatic do_write(input int p, input int n, input string req);
    logic ak;
    logic [7:0] d;
    bus_start();
    wr_byte({ADDR, 1'b0}, ak); check({req, " addr ack"}, ak, 1);
    wr_byte(8'(p), ak);        check({req, " ptr ack"}, ak, 1);
    mptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wr_byte(d, ak); check({req, " data ack"}, ak, 1);
      model[mptr] = d;
      mptr = nxt(mptr);
    end
    bus_stop();
  endtask

  task automatic do_read(input int p, input bit setp, input int n, input string req);
    logic ak;
    logic [7:0] d;
    bus_start();
    if (setp) begin
      wr_byte({ADDR, 1'b0}, ak); check({req, " addr ack"}, ak, 1);
      wr_byte(8'(p), ak);        check({req, " ptr ack"}, ak, 1);
      mptr = p;
      bus_start();
    end
    wr_byte({ADDR, 1'b1}, ak); check({req, " read addr ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);
      check({req, " read data"}, d, model[mptr]);
      mptr = nxt(mptr);
    end
    bus_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 oe after reset", sda_oe, 0);
    do_read(0, 1'b0, 2, "R1 R10 reset contents");

    do_write(14, 4, "R5 wrap write");
    do_read(14, 1'b1, 4, "R6 wrap read");
    do_read(0, 1'b0, 3, "R10 continue");

    bus_start();
    wr_byte({7'h15, 1'b0}, ak); check("R3 mismatch no ack", ak, 0);
    wr_byte(8'h03, ak);         check("R3 later byte no ack", ak, 0);
    wr_byte(8'h5A, ak);         check("R3 data no ack", ak, 0);
    bus_stop();
    check("R3 released", sda_oe, 0);
    do_read(3, 1'b1, 1, "R3 reg unchanged");

    bus_start();
    wr_byte({ADDR, 1'b0}, ak); check("R4 addr ack", ak, 1);
    wr_byte(8'd16, ak);        check("R4 ptr out of range nack", ak, 0);
    wr_byte(8'hC3, ak);        check("R4 data after nack", ak, 0);
    bus_stop();
    do_read(0, 1'b0, 1, "R4 ptr kept");

    do_read(7, 1'b1, 1, "R7 setup");
    bus_start();
    wr_byte({ADDR, 1'b1}, ak); check("R7 addr ack", ak, 1);
    rd_byte(1'b1, d); check("R7 last data", d, model[mptr]);
    mptr = nxt(mptr);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    check("R7 released after nack", d, 8'hFF);
    bus_stop();

    bus_start();
    wr_byte({ADDR, 1'b0}, ak); check("R8 addr ack", ak, 1);
    wr_byte(8'd3, ak);         check("R8 ptr ack", ak, 1);
    mptr = 3;
    for (int i = 0; i < 4; i++) send_bit(~model[3][7 - i]);
    bus_start();
    wr_byte({ADDR, 1'b1}, ak); check("R8 start abort readdr ack", ak, 1);
    rd_byte(1'b1, d); check("R8 start abort no write", d, model[3]);
    mptr = nxt(mptr);
    bus_stop();

    bus_start();
    wr_byte({ADDR, 1'b0}, ak); check("R8 addr ack 2", ak, 1);
    wr_byte(8'd5, ak);         check("R8 ptr ack 2", ak, 1);
    mptr = 5;
    for (int i = 0; i < 5; i++) send_bit(~model[5][7 - i]);
    bus_stop();
    check("R8 idle after stop", sda_oe, 0);
    do_read(5, 1'b0, 1, "R8 stop abort no write");

    for (int t = 0; t < 20; t++) begin
      int p, n;
      p = $urandom_range(DEPTH - 1);
      n = $urandom_range(5, 1);
      if ($urandom_range(1)) do_write(p, n, "R5 random write");
      else do_read(p, 1'b1, n, "R6 random read");
    end

    check("R9 oe steady while clock high", viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule